// File: doc/BRIEF.md
# Flash Security Access Gate

This block stands between an external programming port and an on-chip program-storage array. Every command from the port (read, byte program, page erase, mass erase) carries an address and, for a program, a data byte. Depending on a one-byte option register kept in the last location of the array, the gate forwards the command, refuses it with an error, or replaces the returned read data with all ones. A small parameterized array with erased-to-all-ones behaviour is part of the block, so that the protection rules can be checked end to end.

The option register has a fixed field layout that the rest of the chip decodes: bit 5 turns read/write protection on, bit 2 enables the watchdog, bit 1 enables the low-power stop mode, bit 0 selects the boot source, and bits 7, 6, 4 and 3 are reserved as zero. Protection is in force only while the option byte has been programmed since the last erase of its page and its bit 5 is 1. The option byte can be read at any time through the all-ones alias address, and it is written only once per erase of the last page. Each command gets a registered, one-cycle response.

Top module: `flash_sec_gate`

## Requirements
- R1: After reset every array location reads 8'hFF, secure_o is 0 and no response is pending.
- R2: A command presented with cmd_valid high at a rising edge produces rsp_done high for exactly the following cycle; rsp_done is low in any cycle not preceded by a command.
- R3: Opcodes are 0 read, 1 byte program, 2 page erase, 3 mass erase. With protection off, a program stores the byte unchanged, a read returns the stored byte, and rsp_err stays 0.
- R4: Protection is on exactly when the option byte was programmed since its page was last erased and its bit 5 is 1; while on, every read returns 8'hFF except a read at address 16'hFFFF.
- R5: While protection is on, byte programs (to any address, including the option byte) and page erases are refused with rsp_err=1 and leave the array unchanged.
- R6: A mass erase always executes: it sets every location to 8'hFF and turns protection off.
- R7: Once on, protection stays on until a mass erase; no other command turns it off.
- R8: Address 16'hFFFF aliases the last array location, which holds the option byte; a read there returns the option byte whether or not protection is on, and a program there writes the option byte.
- R9: An option-byte write is refused with rsp_err=1 if any byte of the last page has been programmed since that page was last erased (page erase or mass erase).
- R10: An accepted option-byte write stores the data with bits 7, 6, 4 and 3 forced to 0 (stored = data & 8'h27).
- R11: A page erase sets to 8'hFF exactly the 32 bytes of the addressed page (address bits [7:5] select the page) and no other byte; erasing the last page also clears its written state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Opcode: 0 read, 1 program, 2 page erase, 3 mass erase |
| cmd_addr | input | 16 | Byte address; 16'hFFFF is the option-byte alias |
| cmd_wdata | input | 8 | Data byte for a program |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Command refused by protection or by the option write-once rule |
| rsp_rdata | output | 8 | Read result (0 for other commands) |
| secure_o | output | 1 | Protection currently in force |
| opt_o | output | 8 | Stored option byte (8'hFF when erased) |

## Verification
The assertions take for granted that cmd_op, cmd_addr and cmd_wdata carry known values whenever cmd_valid is high, and that the gate accepts one command per cycle with no back-pressure, so a command may follow the previous one at the very next edge. The stimulus drives every field to a defined value on each falling edge, issues commands back to back as well as with idle gaps, and confines random addresses to the first page, the last page, the physical option location and the alias so that the protection and write-once paths are hit often.

// File: rtl/flash_sec_pkg.sv
package flash_sec_pkg;

  localparam int BYTE_W = 8;
  localparam int SEC_BIT = 5;
  localparam logic [BYTE_W-1:0] ERASED_BYTE = 8'hFF;
  // Bits that an option write may set: protect (5), watchdog (2), stop mode (1), boot source (0)
  localparam logic [BYTE_W-1:0] OPT_KEEP_MASK = 8'h27;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_PROG   = 2'd1,
    OP_PERASE = 2'd2,
    OP_MERASE = 2'd3
  } fsg_op_e;

endpackage

// File: rtl/fsg_addr_decode.sv
module fsg_addr_decode #(
  parameter int ADDR_W  = 16,
  parameter int ARR_AW  = 8,
  parameter int PAGE_AW = 5,
  localparam int PG_W   = ARR_AW - PAGE_AW
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ARR_AW-1:0] idx,
  output logic [PG_W-1:0]   page,
  output logic              is_alias,
  output logic              is_opt,
  output logic              in_last_page
);

  always_comb begin
    is_alias     = &addr;
    idx          = is_alias ? {ARR_AW{1'b1}} : addr[ARR_AW-1:0];
    is_opt       = &idx;
    page         = idx[ARR_AW-1:PAGE_AW];
    in_last_page = &page;
  end

endmodule

// File: rtl/fsg_policy.sv
module fsg_policy
  import flash_sec_pkg::*;
(
  input  logic              cmd_valid,
  input  fsg_op_e           op,
  input  logic              is_alias,
  input  logic              is_opt,
  input  logic              in_last_page,
  input  logic              secure,
  input  logic              page_dirty,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] rd_raw,
  input  logic [BYTE_W-1:0] opt_word,
  output logic              prog_en,
  output logic [BYTE_W-1:0] prog_data,
  output logic              perase_en,
  output logic              merase_en,
  output logic              blocked,
  output logic [BYTE_W-1:0] rd_val,
  output logic              set_opt,
  output logic              set_dirty,
  output logic              clr_flags
);

  logic is_prog, is_perase, prog_ok;

  always_comb begin
    is_prog   = cmd_valid && (op == OP_PROG);
    is_perase = cmd_valid && (op == OP_PERASE);
    merase_en = cmd_valid && (op == OP_MERASE);

    // option byte: no protection and a clean last page; other bytes: no protection
    prog_ok   = is_opt ? (!secure && !page_dirty) : !secure;
    prog_en   = is_prog && prog_ok;
    prog_data = is_opt ? (wdata & OPT_KEEP_MASK) : wdata;
    set_dirty = prog_en && in_last_page;
    set_opt   = prog_en && is_opt;

    perase_en = is_perase && !secure;
    clr_flags = merase_en || (perase_en && in_last_page);

    blocked   = (is_prog && !prog_ok) || (is_perase && secure);

    if (is_alias)    rd_val = opt_word;
    else if (secure) rd_val = ERASED_BYTE;
    else             rd_val = rd_raw;
  end

endmodule

// File: rtl/fsg_array.sv
module fsg_array
  import flash_sec_pkg::*;
#(
  parameter int ARR_AW   = 8,
  parameter int PAGE_AW  = 5,
  localparam int PG_W    = ARR_AW - PAGE_AW,
  localparam int DEPTH   = 1 << ARR_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [ARR_AW-1:0] prog_idx,
  input  logic [BYTE_W-1:0] prog_data,
  input  logic              perase_en,
  input  logic [PG_W-1:0]   perase_page,
  input  logic              merase_en,
  input  logic [ARR_AW-1:0] rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] opt_data
);

  logic [DEPTH*BYTE_W-1:0] mem_flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam logic [ARR_AW-1:0] WIDX = ARR_AW'(i);
    logic              erase_hit, prog_hit, word_we;
    logic [BYTE_W-1:0] word_d, word_q;

    always_comb begin
      erase_hit = merase_en || (perase_en && (perase_page == WIDX[ARR_AW-1:PAGE_AW]));
      prog_hit  = prog_en && (prog_idx == WIDX);
      word_we   = erase_hit || prog_hit;
      word_d    = erase_hit ? ERASED_BYTE : prog_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= ERASED_BYTE;
      else if (word_we) word_q <= word_d;
    end

    assign mem_flat[i*BYTE_W +: BYTE_W] = word_q;
  end

  assign rd_data  = mem_flat[int'(rd_idx)*BYTE_W +: BYTE_W];
  assign opt_data = mem_flat[DEPTH*BYTE_W-1 -: BYTE_W];

endmodule

// File: rtl/flash_sec_gate.sv
module flash_sec_gate
  import flash_sec_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int ARR_AW  = 8,
  parameter int PAGE_AW = 5,
  localparam int PG_W   = ARR_AW - PAGE_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BYTE_W-1:0] cmd_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic              secure_o,
  output logic [BYTE_W-1:0] opt_o
);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fsg_op_e op;
  assign op = fsg_op_e'(cmd_op);

  logic [ARR_AW-1:0] idx;
  logic [PG_W-1:0]   page;
  logic              is_alias, is_opt, in_last_page;

  fsg_addr_decode #(.ADDR_W(ADDR_W), .ARR_AW(ARR_AW), .PAGE_AW(PAGE_AW)) u_dec (
    .addr         (cmd_addr),
    .idx          (idx),
    .page         (page),
    .is_alias     (is_alias),
    .is_opt       (is_opt),
    .in_last_page (in_last_page)
  );

  logic              opt_set_q, opt_set_d, dirty_q, dirty_d, flag_we;
  logic              secure;
  logic [BYTE_W-1:0] rd_raw, opt_word, prog_data, rd_val;
  logic              prog_en, perase_en, merase_en, blocked, set_opt, set_dirty, clr_flags;

  assign secure = opt_set_q && opt_word[SEC_BIT];

  fsg_policy u_pol (
    .cmd_valid    (cmd_valid),
    .op           (op),
    .is_alias     (is_alias),
    .is_opt       (is_opt),
    .in_last_page (in_last_page),
    .secure       (secure),
    .page_dirty   (dirty_q),
    .wdata        (cmd_wdata),
    .rd_raw       (rd_raw),
    .opt_word     (opt_word),
    .prog_en      (prog_en),
    .prog_data    (prog_data),
    .perase_en    (perase_en),
    .merase_en    (merase_en),
    .blocked      (blocked),
    .rd_val       (rd_val),
    .set_opt      (set_opt),
    .set_dirty    (set_dirty),
    .clr_flags    (clr_flags)
  );

  fsg_array #(.ARR_AW(ARR_AW), .PAGE_AW(PAGE_AW)) u_arr (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .prog_en     (prog_en),
    .prog_idx    (idx),
    .prog_data   (prog_data),
    .perase_en   (perase_en),
    .perase_page (page),
    .merase_en   (merase_en),
    .rd_idx      (idx),
    .rd_data     (rd_raw),
    .opt_data    (opt_word)
  );

  // option-written and last-page-written flags
  always_comb begin
    flag_we   = clr_flags || set_opt || set_dirty;
    opt_set_d = clr_flags ? 1'b0 : (set_opt   ? 1'b1 : opt_set_q);
    dirty_d   = clr_flags ? 1'b0 : (set_dirty ? 1'b1 : dirty_q);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      opt_set_q <= 1'b0;
      dirty_q   <= 1'b0;
    end else if (flag_we) begin
      opt_set_q <= opt_set_d;
      dirty_q   <= dirty_d;
    end
  end

  // registered response
  logic              done_d, err_d;
  logic [BYTE_W-1:0] rdata_d;

  always_comb begin
    done_d  = cmd_valid;
    err_d   = blocked;
    rdata_d = (cmd_valid && op == OP_READ) ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done  <= done_d;
      rsp_err   <= err_d;
      rsp_rdata <= rdata_d;
    end
  end

  assign secure_o = secure;
  assign opt_o    = opt_word;

  AST_DONE_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd_valid |=> rsp_done) else $error("done missing"); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cmd_valid |=> !rsp_done) else $error("spurious done"); // R2
  AST_SECURE_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && cmd_op == 2'd0 && secure_o && !(&cmd_addr)) |=> (rsp_rdata == 8'hFF)) else $error("unmasked read"); // R4
  AST_ALIAS_READS_OPTION: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && cmd_op == 2'd0 && (&cmd_addr)) |=> (rsp_rdata == $past(opt_o))) else $error("alias read"); // R8
  AST_SECURE_REFUSES_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && secure_o && (cmd_op == 2'd1 || cmd_op == 2'd2)) |=> (rsp_err && $stable(opt_o))) else $error("write not refused"); // R5
  AST_MERASE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && cmd_op == 2'd3) |=> (!secure_o && opt_o == 8'hFF && !rsp_err)) else $error("mass erase"); // R6
  AST_SECURE_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (secure_o && !(cmd_valid && cmd_op == 2'd3)) |=> secure_o) else $error("protection dropped"); // R7
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    opt_set_q |-> ((opt_o & ~OPT_KEEP_MASK) == 8'h00)) else $error("reserved bit set"); // R10

endmodule

// File: tb/flash_sec_gate_tb_top.sv
module flash_sec_gate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [15:0] cmd_addr = 16'h0;
  logic [7:0]  cmd_wdata = 8'h0;
  logic        rsp_done, rsp_err, secure_o;
  logic [7:0]  rsp_rdata, opt_o;

  int errors = 0;
  int checks = 0;
  bit chk_en = 1'b0;
  bit finished = 1'b0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  flash_sec_gate dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .secure_o(secure_o), .opt_o(opt_o)
  );

  // behavioural reference: 256 bytes, 32-byte pages, option byte at index 255
  logic [7:0] m [256];
  bit   m_optset, m_dirty;
  bit   e_done, e_err, e_sec;
  logic [7:0] e_rdata, e_opt;
  string e_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < 256; j++) m[j] = 8'hFF;
      m_optset = 0; m_dirty = 0;
      e_done = 0; e_err = 0; e_rdata = 8'h00; e_sec = 0; e_opt = 8'hFF;
    end else begin
      bit al, sec, isopt;
      int idx;
      e_tag = cur_tag;
      e_done = cmd_valid; e_err = 0; e_rdata = 8'h00;
      if (cmd_valid) begin
        al    = (cmd_addr == 16'hFFFF);
        idx   = al ? 255 : int'(cmd_addr[7:0]);
        isopt = (idx == 255);
        sec   = m_optset && m[255][5];
        case (cmd_op)
          2'd0: e_rdata = al ? m[255] : (sec ? 8'hFF : m[idx]);
          2'd1: begin
            if (sec || (isopt && m_dirty)) e_err = 1;
            else begin
              m[idx] = isopt ? (cmd_wdata & 8'h27) : cmd_wdata;
              if (idx >= 224) m_dirty = 1;
              if (isopt) m_optset = 1;
            end
          end
          2'd2: begin
            if (sec) e_err = 1;
            else begin
              for (int j = (idx / 32) * 32; j < (idx / 32) * 32 + 32; j++) m[j] = 8'hFF;
              if (idx >= 224) begin m_optset = 0; m_dirty = 0; end
            end
          end
          default: begin
            for (int j = 0; j < 256; j++) m[j] = 8'hFF;
            m_optset = 0; m_dirty = 0;
          end
        endcase
      end
      e_sec = m_optset && m[255][5];
      e_opt = m[255];
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (chk_en && !finished) begin
      checks++;
      if (rsp_done !== e_done || rsp_err !== e_err || rsp_rdata !== e_rdata ||
          secure_o !== e_sec || opt_o !== e_opt) begin
        errors++;
        $display("FAIL %s: actual done=%0b err=%0b rdata=%02h sec=%0b opt=%02h expected done=%0b err=%0b rdata=%02h sec=%0b opt=%02h",
                 e_tag, rsp_done, rsp_err, rsp_rdata, secure_o, opt_o,
                 e_done, e_err, e_rdata, e_sec, e_opt);
      end
    end
  end

  task automatic cmd(input logic [1:0] op, input logic [15:0] addr, input logic [7:0] data, input string tag);
    @(negedge clk);
    cur_tag = tag; cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_wdata = data;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmd_valid = 1'b0; cur_tag = "R2";
    end
  endtask

  task automatic finish_run;
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    checks++;
    if (secure_o !== 1'b0 || opt_o !== 8'hFF || rsp_done !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual sec=%0b opt=%02h done=%0b expected sec=0 opt=ff done=0", secure_o, opt_o, rsp_done);
    end
    chk_en = 1'b1;
    cmd(2'd0, 16'h0010, 8'h00, "R1");
    cmd(2'd0, 16'h00FF, 8'h00, "R1");
    idle(1);
    // R3 unsecured pass-through, back to back
    cmd(2'd1, 16'h0010, 8'hA5, "R3");
    cmd(2'd1, 16'h0030, 8'h3C, "R3");
    cmd(2'd0, 16'h0010, 8'h00, "R3");
    cmd(2'd0, 16'h0030, 8'h00, "R3");
    cmd(2'd0, 16'hFFFF, 8'h00, "R8");
    idle(2);
    // R11 page erase of page 0 only
    cmd(2'd2, 16'h0005, 8'h00, "R11");
    cmd(2'd0, 16'h0010, 8'h00, "R11");
    cmd(2'd0, 16'h0030, 8'h00, "R11");
    // R10 reserved bits forced low, R4 protection on
    cmd(2'd1, 16'hFFFF, 8'hFF, "R10");
    cmd(2'd0, 16'hFFFF, 8'h00, "R8");
    cmd(2'd0, 16'h0030, 8'h00, "R4");
    cmd(2'd0, 16'h00FF, 8'h00, "R4");
    // R5 refusals while protected, R7 stays on
    cmd(2'd1, 16'h0030, 8'h11, "R5");
    cmd(2'd2, 16'h0020, 8'h00, "R5");
    cmd(2'd2, 16'h00E0, 8'h00, "R7");
    cmd(2'd1, 16'hFFFF, 8'h00, "R5");
    cmd(2'd1, 16'h00FF, 8'h00, "R7");
    idle(1);
    // R6 mass erase
    cmd(2'd3, 16'h1234, 8'h00, "R6");
    cmd(2'd0, 16'h0030, 8'h00, "R6");
    // R9 write once
    cmd(2'd1, 16'h00FF, 8'h07, "R9");
    cmd(2'd1, 16'hFFFF, 8'h06, "R9");
    cmd(2'd0, 16'hFFFF, 8'h00, "R9");
    cmd(2'd2, 16'h00E3, 8'h00, "R11");
    cmd(2'd1, 16'hFFFF, 8'h06, "R9");
    cmd(2'd2, 16'hFFFF, 8'h00, "R11");
    cmd(2'd1, 16'h00F0, 8'h5A, "R9");
    cmd(2'd1, 16'hFFFF, 8'h21, "R9");
    cmd(2'd0, 16'h00F0, 8'h00, "R3");
    cmd(2'd3, 16'h0000, 8'h00, "R6");
    idle(1);
    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      int sel;
      logic [15:0] a;
      logic [1:0] o;
      sel = int'($urandom_range(0, 3));
      case (sel)
        0: a = {8'h00, 3'd0, 5'($urandom_range(0, 31))};
        1: a = {8'h00, 3'd7, 5'($urandom_range(0, 31))};
        2: a = 16'hFFFF;
        default: a = 16'h00FF;
      endcase
      sel = int'($urandom_range(0, 19));
      o = (sel < 8) ? 2'd0 : (sel < 15) ? 2'd1 : (sel < 19) ? 2'd2 : 2'd3;
      if ($urandom_range(0, 4) == 0) idle(1);
      cmd(o, a, 8'($urandom_range(0, 255)),
          (o == 2'd0) ? "R4" : (o == 2'd1) ? "R5" : (o == 2'd2) ? "R11" : "R6");
    end
    idle(3);
    finish_run();
  end

endmodule